// File: doc/BRIEF.md
# Oscillator Warm-Up Delay Counter

This block keeps the processor stopped until a freshly started oscillator has had time to settle. It counts ticks of either the fast or the slow oscillator, passes them through a three-stage pre-divider, and advances a 14-bit up-counter. When the counter reaches a programmed value, the block raises a one-cycle interrupt and asserts a CPU-enable output. That output stays high until the next warm-up is started.

A warm-up starts when reset is released, when a control register write is made, or when the power or stop-mode controller pulses a start input. This covers reset release, leaving stop mode, and switching the operating clock mode. The oscillators are modelled as clock-enable pulses sampled on one system clock.

A small register port holds two registers. At address 0 is the control word: source select in bit 0, divide select in bits 2:1, and a run bit in bit 3. At address 1 is the compare value, which sets the upper 10 counter bits. The lower 4 bits of the target are taken as zero.

Top module: `wuc_warmup`

## Requirements
- R1: While reset is asserted, cpu_en_o and irq_o are 0. After reset releases (two-flop synchronised), a warm-up runs with these defaults: fast source, divide-by-1, run=1, compare=1. Release comes 18 clock edges after the reset release, counting the two synchroniser edges.
- R2: Control bit 0 selects the count source: 0 counts fast_en_i ticks and 1 counts slow_en_i ticks. The unselected enable has no effect on the release time.
- R3: Control bits 2:1 hold a value d. The counter advances once per 2^d ticks of the selected source.
- R4: Release occurs when the counter reaches the compare value times 16. A compare value of 0 means 16384 counter steps.
- R5: irq_o is high for exactly one cycle, in the same cycle that cpu_en_o first goes high.
- R6: Once high, cpu_en_o stays high and counting stops. Only a start pulse or a control write lowers it. A compare write does not.
- R7: With control bit 3 (run) at 0, the counter does not advance and no release occurs.
- R8: A write to address 0 clears the divider, the counter and cpu_en_o at that edge. Counting resumes on the next enabled source tick, so release follows a full delay measured from the write.
- R9: A start_i pulse clears the divider, the counter and cpu_en_o at that edge and restarts the warm-up with the current settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fast_en_i | input | 1 | Fast oscillator tick (clock enable) |
| slow_en_i | input | 1 | Slow oscillator tick (clock enable) |
| start_i | input | 1 | Warm-up restart pulse from the power/stop controller |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address: 0 control, 1 compare |
| wdata_i | input | 10 | Write data |
| cpu_en_o | output | 1 | CPU operation enable |
| irq_o | output | 1 | Warm-up complete interrupt pulse |

## Verification
The assertions check on every cycle that the interrupt is a single-cycle pulse tied to the rising edge of CPU-enable, and that CPU-enable holds. They also check that a start pulse or a control write drops CPU-enable on the next cycle, and that a halted counter never releases. Only the bench scenarios can show that the release happens at the exact edge set by the source, divide and compare settings. The same applies to the wrap case with a zero compare value, to ignoring the unselected oscillator, and to the restart of the full delay after a mid-count write.

// File: rtl/wuc_pkg.sv
package wuc_pkg;
  typedef enum logic {SRC_FAST = 1'b0, SRC_SLOW = 1'b1} wuc_src_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CMP  = 1'b1;

  // control word bit positions
  localparam int CTL_SRC_BIT = 0;
  localparam int CTL_DIV_LSB = 1;
  localparam int CTL_RUN_BIT = 3;
endpackage

// File: rtl/wuc_regs.sv
module wuc_regs
  import wuc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DIV_W  = 2,
  parameter logic [DATA_W-1:0] CMP_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output wuc_src_e          src_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              run_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              ctrl_wr_o
);
  wuc_src_e          src_q, src_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              run_q, run_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic              ctl_we, cmp_we;

  assign ctl_we = wr_i && (addr_i == ADDR_CTRL);
  assign cmp_we = wr_i && (addr_i == ADDR_CMP);

  always_comb begin
    src_d = src_q;
    div_d = div_q;
    run_d = run_q;
    cmp_d = cmp_q;
    if (ctl_we) begin
      src_d = wuc_src_e'(wdata_i[CTL_SRC_BIT]);
      div_d = wdata_i[CTL_DIV_LSB +: DIV_W];
      run_d = wdata_i[CTL_RUN_BIT];
    end
    if (cmp_we) begin
      cmp_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_FAST;
      div_q <= '0;
      run_q <= 1'b1;
      cmp_q <= CMP_RST;
    end else begin
      src_q <= src_d;
      div_q <= div_d;
      run_q <= run_d;
      cmp_q <= cmp_d;
    end
  end

  assign src_o     = src_q;
  assign div_o     = div_q;
  assign run_o     = run_q;
  assign cmp_o     = cmp_q;
  assign ctrl_wr_o = ctl_we;
endmodule

// File: rtl/wuc_prescale.sv
module wuc_prescale #(
  parameter int STAGES = 3,
  parameter int DIV_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  logic [STAGES-1:0] pre_q, pre_d;
  logic [STAGES:0]   carry;

  assign carry[0] = tick_i;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign carry[s+1] = carry[s] & pre_q[s];
  end

  always_comb begin
    pre_d = pre_q;
    if (clr_i)       pre_d = '0;
    else if (tick_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign step_o = !clr_i && (int'(div_i) <= STAGES) && carry[div_i];
endmodule

// File: rtl/wuc_counter.sv
module wuc_counter #(
  parameter int CNT_W  = 14,
  parameter int FINE_W = 4,
  localparam int CMP_W = CNT_W - FINE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CMP_W-1:0] cmp_i,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, target;

  assign cnt_inc = cnt_q + 1'b1;
  assign target  = {cmp_i, {FINE_W{1'b0}}};

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (step_i) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign match_o = step_i && !clr_i && (cnt_inc == target);
endmodule

// File: rtl/wuc_warmup.sv
module wuc_warmup
  import wuc_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int FINE_W = 4,
  parameter int STAGES = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fast_en_i,
  input  logic                    slow_en_i,
  input  logic                    start_i,
  input  logic                    wr_i,
  input  logic                    addr_i,
  input  logic [CNT_W-FINE_W-1:0] wdata_i,
  output logic                    cpu_en_o,
  output logic                    irq_o
);
  localparam int CMP_W = CNT_W - FINE_W;
  localparam int DIV_W = $clog2(STAGES + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_s;
  wuc_src_e         src;
  logic [DIV_W-1:0] div;
  logic             run_q;
  logic [CMP_W-1:0] cmp;
  logic             ctrl_wr, clr, tick, step, match;
  logic             done_q, done_d, irq_q, irq_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  wuc_regs #(.DATA_W(CMP_W), .DIV_W(DIV_W)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_s),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .src_o    (src),
    .div_o    (div),
    .run_o    (run_q),
    .cmp_o    (cmp),
    .ctrl_wr_o(ctrl_wr)
  );

  assign clr  = ctrl_wr || start_i;
  assign tick = run_q && !done_q &&
                ((src == SRC_SLOW) ? slow_en_i : fast_en_i);

  wuc_prescale #(.STAGES(STAGES), .DIV_W(DIV_W)) pre_i (
    .clk_i (clk_i),
    .rst_ni(rst_s),
    .clr_i (clr),
    .tick_i(tick),
    .div_i (div),
    .step_o(step)
  );

  wuc_counter #(.CNT_W(CNT_W), .FINE_W(FINE_W)) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_s),
    .clr_i  (clr),
    .step_i (step),
    .cmp_i  (cmp),
    .match_o(match)
  );

  always_comb begin
    done_d = done_q;
    irq_d  = 1'b0;
    if (clr) begin
      done_d = 1'b0;
    end else if (match) begin
      done_d = 1'b1;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  assign cpu_en_o = done_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/wuc_warmup_chk.sv
module wuc_warmup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic wr_i,
  input logic addr_i,
  input logic run_i,
  input logic cpu_en_o,
  input logic irq_o
);
  p_irq_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_en_o) |-> irq_o);

  p_rise_on_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cpu_en_o);

  p_en_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en_o && !start_i && !(wr_i && !addr_i)) |=> cpu_en_o);

  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !cpu_en_o);

  p_ctrl_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i) |=> !cpu_en_o);

  p_halt_no_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !$rose(cpu_en_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r1: assert (!irq_o && !cpu_en_o);
    end
  end
endmodule

bind wuc_warmup wuc_warmup_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .run_i   (run_q),
  .cpu_en_o(cpu_en_o),
  .irq_o   (irq_o)
);

// File: tb/wuc_warmup_tb.sv
`timescale 1ns/1ps
module wuc_warmup_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SLOW_P     = 3;
  localparam int  NVEC       = 6;
  // each row: source select, divide select, compare value
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 1}, '{0, 2, 1}, '{0, 3, 2},
    '{1, 0, 1}, '{1, 1, 3}, '{1, 3, 1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fast_en, slow_en, start, wr, addr;
  logic [9:0] wdata;
  logic       cpu_en, irq;

  int checks = 0;
  int fails  = 0;
  int cur_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wuc_warmup dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .fast_en_i(fast_en),
    .slow_en_i(slow_en),
    .start_i  (start),
    .wr_i     (wr),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .cpu_en_o (cpu_en),
    .irq_o    (irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] ctl(input int sel, input int div, input bit run);
    return 10'(sel) | (10'(div) << 1) | (10'(run) << 3);
  endfunction

  task automatic write_cmp(input int v);
    @(negedge clk);
    wr = 1'b1; addr = 1'b1; wdata = 10'(v);
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  // kick at one edge (control write or start pulse), then count edges to irq
  task automatic kick_and_measure(input bit use_start, input logic [9:0] cw,
                                  input int limit, output int k);
    @(negedge clk);
    slow_en = 1'b0;
    if (use_start) start = 1'b1;
    else begin wr = 1'b1; addr = 1'b0; wdata = cw; end
    @(posedge clk);
    k = 0;
    forever begin
      @(negedge clk);
      wr = 1'b0; start = 1'b0;
      if (k == 0) check(cpu_en == 1'b0, use_start ? "R9" : "R8", cpu_en, 0);
      if (irq || k >= limit) break;
      slow_en = ((k + 1) % SLOW_P) == 0;
      @(posedge clk);
      k++;
    end
    slow_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k, t;
    rst_n = 1'b0; fast_en = 1'b1; slow_en = 1'b0; start = 1'b0;
    wr = 1'b0; addr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    check(cpu_en == 1'b0 && irq == 1'b0, "R1", {cpu_en, irq}, 0);

    // R1: default warm-up after reset release
    rst_n = 1'b1;
    k = 0;
    forever begin
      @(posedge clk); k++;
      @(negedge clk);
      if (irq || k > 100) break;
    end
    check(k == 18, "R1", k, 18);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      cur_sel = VEC[i][0];
      t = VEC[i][2] * 16 * (1 << VEC[i][1]) * (VEC[i][0] != 0 ? SLOW_P : 1);
      write_cmp(VEC[i][2]);
      kick_and_measure(1'b0, ctl(VEC[i][0], VEC[i][1], 1'b1), t + 50, k);
      check(k == t, VEC[i][0] != 0 ? "R2" : "R3", k, t);
      @(negedge clk);
      check(irq == 1'b0 && cpu_en == 1'b1, "R5", {irq, cpu_en}, 1);
    end

    // R6: compare write keeps cpu_en high, no new irq
    write_cmp(5);
    repeat (20) @(negedge clk);
    check(cpu_en == 1'b1 && irq == 1'b0, "R6", {cpu_en, irq}, 2);

    // R9: start pulse restarts with current settings (fast, /1, cmp 1)
    write_cmp(1);
    kick_and_measure(1'b0, ctl(0, 0, 1'b1), 100, k);
    kick_and_measure(1'b1, '0, 100, k);
    check(k == 16, "R9", k, 16);

    // R7: run=0 never releases
    kick_and_measure(1'b0, ctl(0, 0, 1'b0), 300, k);
    check(k == 300 && cpu_en == 1'b0, "R7", k, 300);

    // R8: control write mid-count restarts the full delay
    kick_and_measure(1'b0, ctl(0, 0, 1'b1), 10, k);
    check(cpu_en == 1'b0, "R8", cpu_en, 0);
    kick_and_measure(1'b0, ctl(0, 0, 1'b1), 100, k);
    check(k == 16, "R8", k, 16);

    // R4: compare 0 wraps the full counter
    write_cmp(0);
    kick_and_measure(1'b0, ctl(0, 0, 1'b1), 17000, k);
    check(k == 16384, "R4", k, 16384);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule